// File: doc/BRIEF.md
# Staged Switch Command Decoder

This block sits behind a serial slave interface and turns command bytes into enables for twelve analog switches. The switches form six two-input multiplexers, and each multiplexer has an A side and a B side. Every accepted write carries a command byte, an apply flag and a keep flag. Bit 7 of the command byte is the on/off value and bits 6:0 are a target code. The block edits a pending copy of the switch enables. The live switch enables change only when a write arrives with the apply flag set, and that write also brings in all the edits staged since the previous apply.

Inside each multiplexer, at most one side is on at any time. When an apply moves a multiplexer from one side to the other, the side that was on is dropped for one full clock before the new side closes. A write with the keep flag low is a software reset: it clears every switch, both pending and live, and its own command byte is discarded. The block also returns a 16-bit status word built from the live switch enables.

Top module: `mux_cmd_stager`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after a write with `cmd_keep` = 0, all twelve switch enables are 0. The pending state is cleared as well, so a later apply that carries only reserved commands leaves every switch open.
- R2: A write with `cmd_apply` = 0 changes no switch output. It only edits the pending state.
- R3: A write with `cmd_apply` = 1 and `cmd_keep` = 1 first applies its own command to the pending state. The outputs for every multiplexer that does not change sides then follow the result at the first clock edge after the write's edge.
- R4: Code 0 addresses all six A switches and code 1 addresses all six B switches. With bit 7 = 1, that side turns on and the opposite side of every multiplexer turns off. With bit 7 = 0, that side turns off.
- R5: For multiplexer index m (0 to 5), code 2m+2 addresses its A switch and code 2m+3 addresses its B switch. Bit 7 sets the addressed switch on or off.
- R6: Codes 14 to 19 disable multiplexer index 0 to 5, opening both of its switches whatever bit 7 is. Byte 0x1F (code 31, bit 7 = 0) opens every switch.
- R7: Every other byte leaves the pending state unchanged. This includes code 20 with either value of bit 7, byte 0x9F, and any code above 31. An apply that carries such a byte still commits the earlier staged edits.
- R8: Turning one side of a multiplexer on forces its other side off, and the two outputs of one multiplexer are never 1 together.
- R9: When several staged commands address the same switch before an apply, only the last one takes effect.
- R10: When an apply moves a multiplexer from one side to the other, both of its outputs are 0 at the first edge after the write. The new side turns on at the second edge.
- R11: `status_word` bit 15−2m is the live A enable of multiplexer m, and bit 14−2m is its live B enable. Bits 3:0 are 0.
- R12: The command byte of a write with `cmd_keep` = 0 is ignored, even if `cmd_apply` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | One-cycle strobe for a complete write |
| cmd_byte | input | 8 | Bit 7 is the on/off value, bits 6:0 are the target code |
| cmd_apply | input | 1 | 1: commit the pending state to the live outputs with this write |
| cmd_keep | input | 1 | 0: software reset of all switches, command ignored |
| sw_a_on | output | 6 | Live A-side enable, one bit per multiplexer |
| sw_b_on | output | 6 | Live B-side enable, one bit per multiplexer |
| status_word | output | 16 | Readback of the live switch enables |

## Verification
A corrupted pending register stays invisible until the next apply. At that point it shows up one edge later as wrong enables on multiplexers that the apply's own command never touched, so the bench stages edits and reserved bytes and then commits with unrelated codes. A fault in the goal or live stepping shows up sooner: a change-over either closes both sides together or skips the all-open cycle, at the first or second edge after the apply. The readback word mirrors the live registers in the same cycle, so a wrong bit order is seen as soon as two different multiplexers are on.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int CMD_W  = 8;
  localparam int CODE_W = CMD_W - 1;

  typedef struct packed {
    logic              val;
    logic [CODE_W-1:0] code;
  } cmd_t;
endpackage

// File: rtl/mcs_decode.sv
module mcs_decode
  import mcs_pkg::*;
#(
  parameter int NUM_MUX = 6
) (
  input  logic [NUM_MUX-1:0] cur_a,
  input  logic [NUM_MUX-1:0] cur_b,
  input  cmd_t               cmd,
  output logic [NUM_MUX-1:0] nxt_a,
  output logic [NUM_MUX-1:0] nxt_b
);
  localparam int GRP_A_CODE  = 0;
  localparam int GRP_B_CODE  = 1;
  localparam int SINGLE_BASE = 2;
  localparam int DIS_BASE    = SINGLE_BASE + 2 * NUM_MUX;
  localparam int ALL_OFF     = 31;

  always_comb begin
    nxt_a = cur_a;
    nxt_b = cur_b;
    if (cmd.code == CODE_W'(GRP_A_CODE)) begin
      nxt_a = cmd.val ? '1 : '0;
      if (cmd.val) nxt_b = '0;
    end else if (cmd.code == CODE_W'(GRP_B_CODE)) begin
      nxt_b = cmd.val ? '1 : '0;
      if (cmd.val) nxt_a = '0;
    end else if (cmd.code == CODE_W'(ALL_OFF)) begin
      if (!cmd.val) begin
        nxt_a = '0;
        nxt_b = '0;
      end
    end else begin
      for (int m = 0; m < NUM_MUX; m++) begin
        if (cmd.code == CODE_W'(SINGLE_BASE + 2 * m)) begin
          nxt_a[m] = cmd.val;
          if (cmd.val) nxt_b[m] = 1'b0;
        end
        if (cmd.code == CODE_W'(SINGLE_BASE + 2 * m + 1)) begin
          nxt_b[m] = cmd.val;
          if (cmd.val) nxt_a[m] = 1'b0;
        end
        if (cmd.code == CODE_W'(DIS_BASE + m)) begin
          nxt_a[m] = 1'b0;
          nxt_b[m] = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mcs_live.sv
module mcs_live #(
  parameter int NUM_MUX = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               load,
  input  logic [NUM_MUX-1:0] goal_a_in,
  input  logic [NUM_MUX-1:0] goal_b_in,
  output logic [NUM_MUX-1:0] live_a,
  output logic [NUM_MUX-1:0] live_b
);
  logic [NUM_MUX-1:0] goal_a_q, goal_b_q;
  logic [NUM_MUX-1:0] goal_a_d, goal_b_d;
  logic [NUM_MUX-1:0] step_a, step_b;
  logic [NUM_MUX-1:0] live_a_d, live_b_d;
  logic               goal_en, live_en;

  // one step toward the goal per clock; a side change passes through open
  for (genvar m = 0; m < NUM_MUX; m++) begin : g_step
    logic crossing;
    assign crossing  = (live_a[m] & goal_b_q[m]) | (live_b[m] & goal_a_q[m]);
    assign step_a[m] = crossing ? 1'b0 : goal_a_q[m];
    assign step_b[m] = crossing ? 1'b0 : goal_b_q[m];
  end

  always_comb begin
    goal_en  = clr | load;
    goal_a_d = clr ? '0 : goal_a_in;
    goal_b_d = clr ? '0 : goal_b_in;
    live_en  = clr | (live_a != goal_a_q) | (live_b != goal_b_q);
    live_a_d = clr ? '0 : step_a;
    live_b_d = clr ? '0 : step_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      goal_a_q <= '0;
      goal_b_q <= '0;
    end else if (goal_en) begin
      goal_a_q <= goal_a_d;
      goal_b_q <= goal_b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_a <= '0;
      live_b <= '0;
    end else if (live_en) begin
      live_a <= live_a_d;
      live_b <= live_b_d;
    end
  end
endmodule

// File: rtl/mcs_status.sv
module mcs_status #(
  parameter int NUM_MUX  = 6,
  parameter int STATUS_W = 16
) (
  input  logic [NUM_MUX-1:0]  live_a,
  input  logic [NUM_MUX-1:0]  live_b,
  output logic [STATUS_W-1:0] word
);
  localparam int PAD = STATUS_W - 2 * NUM_MUX;

  for (genvar m = 0; m < NUM_MUX; m++) begin : g_pack
    assign word[STATUS_W-1-2*m] = live_a[m];
    assign word[STATUS_W-2-2*m] = live_b[m];
  end

  if (PAD > 0) begin : g_pad
    assign word[PAD-1:0] = '0;
  end
endmodule

// File: rtl/mux_cmd_stager.sv
module mux_cmd_stager
  import mcs_pkg::*;
#(
  parameter int NUM_MUX  = 6,
  parameter int STATUS_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [CMD_W-1:0]    cmd_byte,
  input  logic                cmd_apply,
  input  logic                cmd_keep,
  output logic [NUM_MUX-1:0]  sw_a_on,
  output logic [NUM_MUX-1:0]  sw_b_on,
  output logic [STATUS_W-1:0] status_word
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic [NUM_MUX-1:0]     pend_a_q, pend_b_q;
  logic [NUM_MUX-1:0]     pend_a_d, pend_b_d;
  logic [NUM_MUX-1:0]     dec_a, dec_b;
  logic                   pend_en, sw_clr, sw_load;
  cmd_t                   cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  assign cmd = cmd_t'(cmd_byte);

  mcs_decode #(.NUM_MUX(NUM_MUX)) decode_i (
    .cur_a (pend_a_q),
    .cur_b (pend_b_q),
    .cmd   (cmd),
    .nxt_a (dec_a),
    .nxt_b (dec_b)
  );

  always_comb begin
    pend_en  = cmd_valid;
    sw_clr   = cmd_valid & ~cmd_keep;
    sw_load  = cmd_valid & cmd_keep & cmd_apply;
    pend_a_d = cmd_keep ? dec_a : '0;
    pend_b_d = cmd_keep ? dec_b : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_a_q <= '0;
      pend_b_q <= '0;
    end else if (pend_en) begin
      pend_a_q <= pend_a_d;
      pend_b_q <= pend_b_d;
    end
  end

  mcs_live #(.NUM_MUX(NUM_MUX)) live_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (sw_clr),
    .load      (sw_load),
    .goal_a_in (dec_a),
    .goal_b_in (dec_b),
    .live_a    (sw_a_on),
    .live_b    (sw_b_on)
  );

  mcs_status #(.NUM_MUX(NUM_MUX), .STATUS_W(STATUS_W)) status_i (
    .live_a (sw_a_on),
    .live_b (sw_b_on),
    .word   (status_word)
  );
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter int NUM_MUX = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_keep,
  input logic [NUM_MUX-1:0] sw_a_on,
  input logic [NUM_MUX-1:0] sw_b_on
);
  AST_MUX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_a_on & sw_b_on) == '0); // R8

  AST_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_a_on & ~$past(sw_a_on) & $past(sw_b_on)) |
     (sw_b_on & ~$past(sw_b_on) & $past(sw_a_on))) == '0); // R10

  AST_SOFT_RESET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_keep) |=> (sw_a_on == '0 && sw_b_on == '0)); // R1

  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !$past(cmd_valid) && !$past(cmd_valid, 2) && !$past(cmd_valid, 3))
      |-> ($stable(sw_a_on) && $stable(sw_b_on))); // R2
endmodule

bind mux_cmd_stager mcs_checker #(.NUM_MUX(NUM_MUX)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_keep  (cmd_keep),
  .sw_a_on   (sw_a_on),
  .sw_b_on   (sw_b_on)
);

// File: tb/mux_cmd_stager_tb_top.sv
module mux_cmd_stager_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [7:0]  cmd_byte;
  logic        cmd_apply;
  logic        cmd_keep;
  logic [5:0]  sw_a_on, sw_b_on;
  logic [15:0] status_word;

  int n_chk;
  int n_bad;
  bit done;

  mux_cmd_stager dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_byte    (cmd_byte),
    .cmd_apply   (cmd_apply),
    .cmd_keep    (cmd_keep),
    .sw_a_on     (sw_a_on),
    .sw_b_on     (sw_b_on),
    .status_word (status_word)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [15:0] exp_status(input logic [5:0] a, input logic [5:0] b);
    logic [15:0] w;
    w = '0;
    for (int m = 0; m < 6; m++) begin
      w[15 - 2 * m] = a[m];
      w[14 - 2 * m] = b[m];
    end
    return w;
  endfunction

  task automatic check_sw(input string req, input logic [5:0] ea, input logic [5:0] eb);
    n_chk++;
    if (sw_a_on !== ea || sw_b_on !== eb) begin
      n_bad++;
      $display("FAIL %s: a=%b b=%b expected a=%b b=%b", req, sw_a_on, sw_b_on, ea, eb);
    end
  endtask

  task automatic check_word(input string req, input logic [15:0] ew);
    n_chk++;
    if (status_word !== ew) begin
      n_bad++;
      $display("FAIL %s: status=%h expected %h", req, status_word, ew);
    end
  endtask

  // one write: driven after a falling edge, sampled at the next rising edge
  task automatic do_write(input logic [7:0] b, input logic apply, input logic keep);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    cmd_apply = apply;
    cmd_keep  = keep;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_apply = 1'b0;
    cmd_keep  = 1'b1;
  endtask

  task automatic stage(input logic [7:0] b);
    do_write(b, 1'b0, 1'b1);
  endtask

  // apply, then wait until a non-crossing change is visible
  task automatic commit(input logic [7:0] b);
    do_write(b, 1'b1, 1'b1);
    @(negedge clk);
  endtask

  task automatic soft_clear();
    do_write(8'h00, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    check_sw("R1 power-up", '0, '0);
    check_word("R11 power-up status", 16'h0000);
  endtask

  task automatic t_stage_commit();
    soft_clear();
    stage(8'h82);
    stage(8'h87);
    repeat (2) @(negedge clk);
    check_sw("R2 staged only", '0, '0);
    commit(8'h8C);
    check_sw("R3 R5 commit", 6'b100001, 6'b000100);
    check_word("R11 status map", exp_status(6'b100001, 6'b000100));
  endtask

  task automatic t_group_swap();
    soft_clear();
    commit(8'h81);
    check_sw("R4 all B on", 6'b000000, 6'b111111);
    do_write(8'h80, 1'b1, 1'b1);
    @(negedge clk);
    check_sw("R10 open step", '0, '0);
    @(negedge clk);
    check_sw("R10 R4 all A on", 6'b111111, 6'b000000);
    check_word("R11 all A status", 16'hAAA0);
    commit(8'h00);
    check_sw("R4 all A off", '0, '0);
  endtask

  task automatic t_excl_last();
    soft_clear();
    stage(8'h82);
    stage(8'h83);
    commit(8'h04);
    check_sw("R8 other side forced off", 6'b000000, 6'b000001);
    stage(8'h84);
    stage(8'h04);
    stage(8'h06);
    stage(8'h86);
    commit(8'h9F);
    check_sw("R9 last wins", 6'b000100, 6'b000001);
  endtask

  task automatic t_disable();
    soft_clear();
    commit(8'h80);
    commit(8'h0F);
    check_sw("R6 disable mux1", 6'b111101, '0);
    commit(8'h91);
    check_sw("R6 disable mux3 with bit7 set", 6'b110101, '0);
    commit(8'h1F);
    check_sw("R6 all off", '0, '0);
  endtask

  task automatic t_reserved();
    soft_clear();
    commit(8'h80);
    commit(8'h94);
    check_sw("R7 code 20 bit7=1", 6'b111111, '0);
    commit(8'h14);
    check_sw("R7 code 20 bit7=0", 6'b111111, '0);
    commit(8'h9F);
    check_sw("R7 0x9F", 6'b111111, '0);
    stage(8'h83);
    commit(8'hA5);
    @(negedge clk);
    check_sw("R7 high code still commits", 6'b111110, 6'b000001);
    commit(8'h7F);
    check_sw("R7 0x7F", 6'b111110, 6'b000001);
  endtask

  task automatic t_soft_reset();
    soft_clear();
    commit(8'h81);
    do_write(8'h80, 1'b1, 1'b0);
    check_sw("R1 soft reset immediate", '0, '0);
    commit(8'h9F);
    check_sw("R12 command byte ignored", '0, '0);
    commit(8'h80);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_sw("R1 pin reset", '0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    commit(8'h9F);
    check_sw("R1 pending cleared by pin reset", '0, '0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_byte  = 8'h00;
    cmd_apply = 1'b0;
    cmd_keep  = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_stage_commit();
    t_group_swap();
    t_excl_last();
    t_disable();
    t_reserved();
    t_soft_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule